// File: doc/BRIEF.md
# Scanned Key Matrix and Display Refresh Controller

This block removes keyboard polling and display multiplexing from the processor. One free-running scan counter selects a row of an 8x8 key matrix and, at the same moment, a character slot of a 16-entry display memory. Every key is debounced on its own. A debounced key becomes an 8-bit code, and that code is queued in an 8-entry FIFO. The processor uses a small register bus to read codes, read status, choose how simultaneous keys are handled, and load display characters.

Each scan slot lasts `SLOT_CYC` clocks. Within a slot, the block looks at one return column per clock, so that at most one code enters the FIFO in a cycle. Two policies are available for overlapping keys. Under lockout, a key is accepted only when it is the only one held. Under rollover, every key is accepted independently of the others.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: During reset and right after it, `irq` is 0, the status register reads 0, the data register reads 0, `disp_idx` and `scan_row` are 0, every display character is 0, and the policy is lockout.
- R2: `disp_idx` advances by one every `SLOT_CYC` (default 8) clocks and wraps from 15 to 0. `scan_row` always equals the low 3 bits of `disp_idx`.
- R3: `disp_data` shows the display character stored at `disp_idx`. Writing address 2 sets the character pointer (bits 3:0). Each write to address 3 stores a character at the pointer and then increments the pointer, which wraps from 15 to 0.
- R4: A key code is {shift_in in bit 7, ctrl_in in bit 6, scan row in bits 5:3, return column in bits 2:0}. Both modifiers are sampled when the code is entered.
- R5: A key is accepted only after it reads closed on two consecutive full matrix scans. A closure that is seen in only one scan produces no code.
- R6: A held key produces exactly one code. It can produce another code only after it has been seen released.
- R7: Under lockout, no code is entered while more than one key is down.
- R8: Under lockout, a blocked key that stays down is entered once all the other keys have been released.
- R9: Under rollover, every key held for two scans is entered, whatever else is down. Keys that become valid in the same scan enter in row-major scan order.
- R10: Reading address 0 returns the oldest code and removes it, so codes leave in the order they entered. Reading address 0 while the FIFO is empty returns 0 and changes nothing.
- R11: `irq` is 1 exactly while the FIFO holds at least one code.
- R12: A code that arrives while the FIFO holds 8 codes is dropped, and the overrun flag (status bit 7) is set. Status bits 3:0 give the number of codes held. Writing address 1 with bit 1 set clears the overrun flag.
- R13: Writing address 1 sets the policy from bit 0: 0 selects lockout and 1 selects rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Read strobe; a read of address 0 pops the FIFO |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 2 | Register address: 0 data, 1 status/command, 2 display pointer, 3 display character |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register (combinational) |
| scan_row | output | 3 | Key matrix row being scanned |
| ret_cols | input | 8 | Return lines of the selected row, 1 = key closed |
| shift_in | input | 1 | Shift modifier level |
| ctrl_in | input | 1 | Control modifier level |
| disp_idx | output | 4 | Display character slot being refreshed |
| disp_data | output | 8 | Character for the current display slot |
| irq | output | 1 | High while the FIFO is not empty |

## Verification
The bench goes after the following corner cases, and each one exposes a specific design error.

- **Closure held for a single slot.** A design that skips the second-scan debounce would queue a false code.
- **Two keys pressed together under lockout.** A design that ignores the other held keys would emit a code too early. A design that never re-examines a blocked key would lose it when its partner is released.
- **Several keys together under rollover.** A design with the wrong scan order would return codes out of sequence.
- **Ninth key while the FIFO is full.** A design with a broken full check would overwrite the oldest entry or fail to raise overrun.
- **Display pointer and slot wrap.** A design with a bad 15-to-0 wrap on the pointer or the slot counter would show the wrong character or skip a slot.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
package kbd_pkg;
  localparam int KEY_ROWS = 8;
  localparam int KEY_COLS = 8;
  localparam int ROW_W    = $clog2(KEY_ROWS);
  localparam int COL_W    = $clog2(KEY_COLS);

  typedef enum logic {
    POL_LOCKOUT  = 1'b0,
    POL_ROLLOVER = 1'b1
  } key_policy_e;

  typedef struct packed {
    logic             shift;
    logic             ctrl;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } key_code_t;

  localparam int CODE_W = $bits(key_code_t);

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_DPTR = 2'd2;
  localparam logic [1:0] REG_DCHR = 2'd3;
endpackage

// File: rtl/kbd_scan_timer.sv
`timescale 1ns/1ps
module kbd_scan_timer #(
  parameter  int SLOT_CYC = 8,
  parameter  int SLOTS    = 16,
  localparam int SUB_W    = $clog2(SLOT_CYC),
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SUB_W-1:0]  sub_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              slot_end
);
  logic [SUB_W-1:0]  sub_d;
  logic [SLOT_W-1:0] slot_d;

  assign slot_end = (sub_q == SUB_W'(SLOT_CYC - 1));

  always_comb begin
    sub_d  = sub_q + 1'b1;
    slot_d = slot_q;
    if (slot_end) begin
      sub_d  = '0;
      slot_d = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      slot_q <= '0;
    end else begin
      sub_q <= sub_d;
      if (slot_end) slot_q <= slot_d;
    end
  end

  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(slot_q)); // R2
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && slot_q == SLOT_W'(SLOTS - 1)) |=> (slot_q == '0)); // R2
endmodule

// File: rtl/kbd_key_tracker.sv
`timescale 1ns/1ps
module kbd_key_tracker
  import kbd_pkg::*;
#(
  parameter  int ROWS   = KEY_ROWS,
  parameter  int COLS   = KEY_COLS,
  parameter  int SUB_W  = 3,
  localparam int RW     = $clog2(ROWS),
  localparam int CW     = $clog2(COLS),
  localparam int KW     = RW + CW,
  localparam int NKEYS  = 1 << KW,
  localparam int ONES_W = KW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [RW-1:0]    row,
  input  logic [SUB_W-1:0] sub,
  input  logic [COLS-1:0]  ret_cols,
  input  key_policy_e policy,
  input  logic        shift_in,
  input  logic        ctrl_in,
  output logic        key_push,
  output key_code_t   key_code
);
  logic [NKEYS-1:0]  seen_q, seen_d;
  logic [NKEYS-1:0]  done_q, done_d;
  logic [CW-1:0]     col_idx;
  logic [KW-1:0]     key_idx;
  logic [ONES_W-1:0] ones;
  logic              eval, closed, lone, allowed, ready;

  always_comb begin
    eval    = (int'(sub) < COLS);
    col_idx = CW'(sub);
    key_idx = {row, col_idx};
    closed  = ret_cols[col_idx];
    ones    = ONES_W'($countones(seen_q));
    lone    = ((ones - ONES_W'(seen_q[key_idx])) == '0);
    allowed = (policy == POL_ROLLOVER) || lone;
    ready   = eval && closed && seen_q[key_idx] && !done_q[key_idx];
    key_push = ready && allowed;
    key_code = '{shift: shift_in, ctrl: ctrl_in, row: row, col: col_idx};
    seen_d = seen_q;
    done_d = done_q;
    seen_d[key_idx] = closed;
    if (!closed)       done_d[key_idx] = 1'b0;
    else if (key_push) done_d[key_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      done_q <= '0;
    end else if (eval) begin
      seen_q <= seen_d;
      done_q <= done_d;
    end
  end

  AST_MARK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |=> done_q[$past(key_idx)]); // R6
  AST_LOCKOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_push && policy == POL_LOCKOUT) |-> ($countones(seen_q) == 1)); // R7
endmodule

// File: rtl/kbd_code_fifo.sv
`timescale 1ns/1ps
module kbd_code_fifo #(
  parameter  int DEPTH = 8,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNTW-1:0]  count,
  output logic             empty,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0]  cnt_d;
  logic             full, push_ok, pop_ok;

  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = count;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = count + 1'b1;
    if (pop_ok && !push_ok) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
      if (push_ok) mem[wp_q] <= din;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH)); // R12
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R12
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R10
endmodule

// File: rtl/kbd_disp_ram.sv
`timescale 1ns/1ps
module kbd_disp_ram #(
  parameter  int CHARS = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(CHARS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_din,
  input  logic             chr_we,
  input  logic [WIDTH-1:0] chr_din,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] ram_q [CHARS];
  logic [AW-1:0]    ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we)      ptr_d = ptr_din;
    else if (chr_we) ptr_d = (ptr_q == AW'(CHARS - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < CHARS; g++) begin : g_char
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ram_q[g] <= '0;
      else if (chr_we && !ptr_we && ptr_q == AW'(g)) ram_q[g] <= chr_din;
    end
  end

  assign rd_data = ram_q[rd_idx];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we && !ptr_we) |=> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R3
endmodule

// File: rtl/kbd_scan_ctrl.sv
`timescale 1ns/1ps
module kbd_scan_ctrl
  import kbd_pkg::*;
#(
  parameter  int SLOT_CYC   = 8,
  parameter  int FIFO_DEPTH = 8,
  parameter  int DISP_CHARS = 16,
  parameter  int CHAR_W     = 8,
  localparam int SUB_W      = $clog2(SLOT_CYC),
  localparam int DISP_W     = $clog2(DISP_CHARS),
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [ROW_W-1:0]  scan_row,
  input  logic [KEY_COLS-1:0] ret_cols,
  input  logic              shift_in,
  input  logic              ctrl_in,
  output logic [DISP_W-1:0] disp_idx,
  output logic [CHAR_W-1:0] disp_data,
  output logic              irq
);
  logic              rst_s1, rst_s2, rst_core_n;
  logic [SUB_W-1:0]  sub;
  logic [DISP_W-1:0] slot;
  logic              slot_end;
  logic              key_push;
  key_code_t         key_code;
  logic [CODE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_drop, fifo_pop;
  key_policy_e       policy_q, policy_d;
  logic              ovr_q, ovr_d, cmd_we;
  logic [7:0]        status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2, rst_s1} <= 2'b00;
    else        {rst_s2, rst_s1} <= {rst_s1, 1'b1};
  end
  assign rst_core_n = rst_s2;

  kbd_scan_timer #(.SLOT_CYC(SLOT_CYC), .SLOTS(DISP_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .sub_q(sub), .slot_q(slot), .slot_end(slot_end));

  assign scan_row = slot[ROW_W-1:0];
  assign disp_idx = slot;

  kbd_key_tracker #(.ROWS(KEY_ROWS), .COLS(KEY_COLS), .SUB_W(SUB_W)) u_track (
    .clk(clk), .rst_n(rst_core_n), .row(scan_row), .sub(sub), .ret_cols(ret_cols),
    .policy(policy_q), .shift_in(shift_in), .ctrl_in(ctrl_in),
    .key_push(key_push), .key_code(key_code));

  assign fifo_pop = cpu_rd && (cpu_addr == REG_DATA);

  kbd_code_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CODE_W)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(key_push), .din(key_code),
    .pop(fifo_pop), .dout(fifo_dout), .count(fifo_cnt), .empty(fifo_empty),
    .drop(fifo_drop));

  kbd_disp_ram #(.CHARS(DISP_CHARS), .WIDTH(CHAR_W)) u_disp (
    .clk(clk), .rst_n(rst_core_n),
    .ptr_we(cpu_wr && cpu_addr == REG_DPTR), .ptr_din(cpu_wdata[DISP_W-1:0]),
    .chr_we(cpu_wr && cpu_addr == REG_DCHR), .chr_din(cpu_wdata[CHAR_W-1:0]),
    .rd_idx(slot), .rd_data(disp_data));

  assign cmd_we = cpu_wr && (cpu_addr == REG_CTRL);

  always_comb begin
    policy_d = policy_q;
    ovr_d    = ovr_q;
    if (cmd_we) begin
      policy_d = key_policy_e'(cpu_wdata[0]);
      if (cpu_wdata[1]) ovr_d = 1'b0;
    end
    if (fifo_drop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      policy_q <= POL_LOCKOUT;
      ovr_q    <= 1'b0;
    end else begin
      policy_q <= policy_d;
      ovr_q    <= ovr_d;
    end
  end

  always_comb begin
    status = '0;
    status[7] = ovr_q;
    status[CNT_W-1:0] = fifo_cnt;
    case (cpu_addr)
      REG_DATA: cpu_rdata = fifo_empty ? '0 : fifo_dout;
      REG_CTRL: cpu_rdata = status;
      default:  cpu_rdata = '0;
    endcase
  end

  assign irq = !fifo_empty;

  AST_IRQ_DRAIN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fifo_pop && fifo_cnt == CNT_W'(1) && !key_push) |=> !irq); // R11
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_core_n)
    fifo_drop |=> ovr_q); // R12
endmodule

// File: tb/kbd_scan_ctrl_bench.sv
`timescale 1ns/1ps
module kbd_scan_ctrl_bench;
  localparam int SCAN_CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       drv_rd, cpu_wr, mon_rd;
  logic [1:0] drv_addr;
  logic       cpu_rd;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [2:0] scan_row;
  logic [7:0] ret_cols;
  logic       shift_in, ctrl_in;
  logic [3:0] disp_idx;
  logic [7:0] disp_data;
  logic       irq;
  logic [7:0] mat [8];
  logic [7:0] dexp [16];

  int checks = 0;
  int fails  = 0;
  bit mon_en = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_e;
  string      mon_t;
  logic [7:0] st;

  always #2.5 clk = ~clk;

  assign cpu_rd   = drv_rd | mon_rd;
  assign cpu_addr = mon_rd ? 2'd0 : drv_addr;
  assign ret_cols = mat[scan_row];

  kbd_scan_ctrl u_kbd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scan_row(scan_row),
    .ret_cols(ret_cols), .shift_in(shift_in), .ctrl_in(ctrl_in),
    .disp_idx(disp_idx), .disp_data(disp_data), .irq(irq));

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic expect_key(input int r, input int c, input string tag);
    exp_q.push_back({shift_in, ctrl_in, 3'(r), 3'(c)});
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    drv_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    bit keep;
    keep = mon_en; mon_en = 0;
    repeat (2) @(negedge clk);
    drv_addr = 2'd1;
    #0.5 v = cpu_rdata;
    mon_en = keep;
  endtask

  task automatic wait_scans(input int n);
    repeat (n * SCAN_CYC) @(negedge clk);
  endtask

  task automatic wait_row0();
    logic [2:0] p;
    p = scan_row;
    forever begin
      @(negedge clk);
      if (scan_row == 3'd0 && p != 3'd0) break;
      p = scan_row;
    end
  endtask

  task automatic release_all();
    @(negedge clk);
    for (int i = 0; i < 8; i++) mat[i] = 8'h00;
  endtask

  task automatic check_display(input int slots);
    logic [3:0] p;
    int n;
    p = disp_idx;
    do @(negedge clk); while (disp_idx == p);
    for (int s = 0; s < slots; s++) begin
      p = disp_idx;
      n = 0;
      chk(disp_data == dexp[disp_idx], "R3 display character", 32'(disp_data), 32'(dexp[disp_idx]));
      chk(scan_row == disp_idx[2:0], "R2 row follows slot", 32'(scan_row), 32'(disp_idx[2:0]));
      do begin @(negedge clk); n++; end while (disp_idx == p);
      chk(n == 8, "R2 slot length", 32'(n), 32'd8);
      chk(disp_idx == 4'(p + 4'd1), "R2 slot step and wrap", 32'(disp_idx), 32'(4'(p + 4'd1)));
    end
  endtask

  // Monitor: pops the FIFO whenever irq is up and compares against the scoreboard.
  initial begin
    mon_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_rd) mon_rd = 1'b0;
      else if (mon_en && irq) begin
        mon_rd = 1'b1;
        #0.5;
        if (exp_q.size() == 0) chk(0, "R10 unexpected code", 32'(cpu_rdata), 32'hFFFF);
        else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          chk(cpu_rdata == mon_e, mon_t, 32'(cpu_rdata), 32'(mon_e));
        end
      end
    end
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; drv_rd = 1'b0; cpu_wr = 1'b0; drv_addr = 2'd0; cpu_wdata = 8'h00;
    shift_in = 1'b0; ctrl_in = 1'b0;
    for (int i = 0; i < 8; i++) mat[i] = 8'h00;
    for (int i = 0; i < 16; i++) dexp[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", 32'(irq), 0);
    chk(disp_idx == 4'd0, "R1 slot in reset", 32'(disp_idx), 0);
    chk(scan_row == 3'd0, "R1 row in reset", 32'(scan_row), 0);
    chk(disp_data == 8'h00, "R1 display in reset", 32'(disp_data), 0);
    drv_addr = 2'd1; #0.5;
    chk(cpu_rdata == 8'h00, "R1 status in reset", 32'(cpu_rdata), 0);
    drv_addr = 2'd0; #0.5;
    chk(cpu_rdata == 8'h00, "R1 data in reset", 32'(cpu_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_display(3);
    mon_en = 1;

    // Display load with auto-increment, then pointer wrap.
    wr(2'd2, 8'h00);
    for (int i = 0; i < 16; i++) begin
      wr(2'd3, 8'hA0 + 8'(i));
      dexp[i] = 8'hA0 + 8'(i);
    end
    check_display(20);
    wr(2'd2, 8'h0F);
    wr(2'd3, 8'h5A); dexp[15] = 8'h5A;
    wr(2'd3, 8'h5B); dexp[0]  = 8'h5B;
    check_display(18);

    // R5: closure seen in one scan only.
    wait_row0();
    do @(negedge clk); while (scan_row != 3'd3);
    mat[3][2] = 1'b1;
    repeat (8) @(negedge clk);
    mat[3][2] = 1'b0;
    wait_scans(3);
    rd_status(st);
    chk(st == 8'h00, "R5 single-scan closure ignored", 32'(st), 0);
    chk(irq == 1'b0, "R5 R11 no irq after glitch", 32'(irq), 0);

    // R1 lockout default, R4 code format, R6 single entry per press.
    shift_in = 1'b1; ctrl_in = 1'b0;
    wait_row0();
    expect_key(2, 5, "R4 R6 code with shift");
    mat[2][5] = 1'b1;
    wait_scans(4);
    rd_status(st);
    chk(st == 8'h00 && exp_q.size() == 0, "R6 held key not repeated", 32'(st), 0);
    release_all();
    wait_scans(2);
    expect_key(2, 5, "R6 re-entry after release");
    mat[2][5] = 1'b1;
    wait_scans(3);
    release_all();
    wait_scans(2);

    // R7/R8: two keys together under lockout.
    shift_in = 1'b0; ctrl_in = 1'b1;
    wait_row0();
    mat[1][0] = 1'b1; mat[6][7] = 1'b1;
    wait_scans(4);
    rd_status(st);
    chk(st == 8'h00, "R7 no code with two keys down", 32'(st), 0);
    expect_key(6, 7, "R8 R4 blocked key entered after partner release");
    @(negedge clk); mat[1][0] = 1'b0;
    wait_scans(3);
    release_all();
    wait_scans(2);

    // R7/R8: second key pressed while first held.
    ctrl_in = 1'b0;
    expect_key(0, 1, "R7 first key alone");
    mat[0][1] = 1'b1;
    wait_scans(3);
    mat[5][3] = 1'b1;
    wait_scans(3);
    rd_status(st);
    chk(st == 8'h00, "R7 second key blocked", 32'(st), 0);
    expect_key(5, 3, "R8 second key after first released");
    @(negedge clk); mat[0][1] = 1'b0;
    wait_scans(3);
    chk(exp_q.size() == 0, "R8 queue drained", 32'(exp_q.size()), 0);
    release_all();
    wait_scans(2);

    // R13/R9: rollover, scan order and keys added while others held.
    wr(2'd1, 8'h01);
    wait_row0();
    expect_key(1, 1, "R9 R13 rollover first");
    expect_key(1, 3, "R9 rollover second");
    expect_key(4, 6, "R9 rollover third");
    mat[1][1] = 1'b1; mat[1][3] = 1'b1; mat[4][6] = 1'b1;
    wait_scans(3);
    expect_key(7, 0, "R9 key added while others held");
    @(negedge clk); mat[7][0] = 1'b1;
    wait_scans(3);
    chk(exp_q.size() == 0, "R9 all rollover codes seen", 32'(exp_q.size()), 0);
    release_all();
    wait_scans(2);

    // R10: read of empty FIFO.
    mon_en = 0;
    repeat (2) @(negedge clk);
    drv_addr = 2'd0; drv_rd = 1'b1; #0.5;
    chk(cpu_rdata == 8'h00, "R10 empty read returns zero", 32'(cpu_rdata), 0);
    @(negedge clk); drv_rd = 1'b0;
    rd_status(st);
    chk(st == 8'h00, "R10 empty read leaves status", 32'(st), 0);

    // R12: nine keys under rollover, no draining.
    wait_row0();
    mat[0] = 8'hFF; mat[1][0] = 1'b1;
    wait_scans(4);
    rd_status(st);
    chk(st == 8'h88, "R12 full count and overrun", 32'(st), 32'h88);
    chk(irq == 1'b1, "R11 irq while not empty", 32'(irq), 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drv_addr = 2'd0; drv_rd = 1'b1; #0.5;
      chk(cpu_rdata == 8'(i), "R10 FIFO order", 32'(cpu_rdata), 32'(i));
      @(negedge clk); drv_rd = 1'b0;
    end
    @(negedge clk);
    chk(irq == 1'b0, "R11 irq drops when empty", 32'(irq), 0);
    rd_status(st);
    chk(st == 8'h80, "R12 ninth code dropped, flag held", 32'(st), 32'h80);
    wr(2'd1, 8'h02);
    rd_status(st);
    chk(st == 8'h00, "R12 overrun cleared", 32'(st), 0);
    release_all();
    wait_scans(2);

    // R13: back to lockout; two keys give nothing.
    mon_en = 1;
    wait_row0();
    mat[2][2] = 1'b1; mat[3][3] = 1'b1;
    wait_scans(4);
    rd_status(st);
    chk(st == 8'h00, "R13 lockout selected again", 32'(st), 0);
    release_all();
    wait_scans(2);
    chk(exp_q.size() == 0, "R10 every expected code arrived", 32'(exp_q.size()), 0);
    report();
  end
endmodule